// File: doc/BRIEF.md
# ESF CRC-6 Check and Generate

This block protects a DS1 bit stream organised in 24-frame extended multiframes with a 6-bit cyclic check word, in both directions at once. On the receive side it divides every multiframe by the generator polynomial and compares the remainder with the six check bits that arrive in the following multiframe. A mismatch produces a one-cycle error pulse. When the mask allows it, the pulse also sets a sticky alarm flag that a clear pulse resets.

On the transmit side it computes the remainder over each outgoing multiframe and writes it into the check-bit positions of the next multiframe. All other bits pass through unchanged. When inversion is enabled, a received error causes all six check bits of exactly one outgoing multiframe to be inverted, which signals the far end. Framing search is done elsewhere. Each direction receives a bit enable, an F-bit strobe and a multiframe-begin strobe. From these the block also produces a begin marker, with an optional second marker at mid-multiframe.

Top module: `esf_crc6_engine`

## Requirements
- R1: The remainder uses the generator x^6 + x + 1. It is cleared at the F-bit flagged as multiframe begin and covers every enabled bit of the multiframe, starting with that F-bit. The coefficient of x^5 is the first bit sent.
- R2: Check bits occupy the F-bit positions of frames 2, 6, 10, 14, 18 and 22 of the multiframe, with frames counted from 1. Frame 2 carries the x^5 coefficient and frame 22 carries the x^0 coefficient.
- R3: The remainder of transmitted multiframe N goes out in multiframe N+1. The first multiframe after reset carries all-zero check bits.
- R4: On the transmit side, every bit outside the six check positions appears on `tx_out` unchanged, in the same cycle.
- R5: `crc_err` pulses for one cycle, in the cycle after the begin F-bit that ends a received multiframe, when any received check bit of that multiframe differs from the remainder of the multiframe before it. The first two multiframes after reset never raise it.
- R6: F-bit positions enter the remainder as ones, whatever value they carry.
- R7: `alarm_irq` is set together with a `crc_err` pulse when `irq_mask` is 1 and stays high until `irq_clr`. A new error in the same cycle as a clear takes precedence. With `irq_mask` at 0, an error leaves the flag unchanged.
- R8: A transmit multiframe has all six check bits inverted exactly when `inv_en` is 1 at its begin F-bit and a `crc_err` pulse occurred after the previous transmit begin, including a pulse in that same cycle. Each error affects at most one multiframe.
- R9: `rx_mark` and `tx_mark` are high for the begin F-bit of their own direction. They are also high for the F-bit of frame 13 (frame index 12), unless `half_mark_off` is 1. At all other times they are low.
- R10: After reset, `crc_err` and `alarm_irq` are 0.
- R11: A cycle with its direction's enable low changes no state of that direction and raises no marker. In such a cycle `tx_out` equals `tx_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive bit valid |
| rx_bit | input | 1 | Receive serial bit |
| rx_fbit | input | 1 | Receive bit is an F-bit |
| rx_mfb | input | 1 | Receive F-bit begins a multiframe |
| tx_en | input | 1 | Transmit bit valid |
| tx_bit | input | 1 | Transmit serial bit from the system side |
| tx_fbit | input | 1 | Transmit bit is an F-bit |
| tx_mfb | input | 1 | Transmit F-bit begins a multiframe |
| inv_en | input | 1 | Enable check-bit inversion after a received error |
| irq_mask | input | 1 | Let received errors set the alarm flag |
| irq_clr | input | 1 | Clear pulse for the alarm flag |
| half_mark_off | input | 1 | Suppress the mid-multiframe marker |
| tx_out | output | 1 | Transmit serial bit with check bits inserted |
| rx_mark | output | 1 | Receive multiframe marker |
| tx_mark | output | 1 | Transmit multiframe marker |
| crc_err | output | 1 | Received multiframe failed its check |
| alarm_irq | output | 1 | Sticky alarm flag |

## Verification
A receive error and a transmit multiframe begin can fall in the same cycle. In that case the error must take effect in the multiframe that starts in that very cycle and must not be kept for a later one. The transmit stream lags the receive stream by one bit, so each receive error pulse meets a transmit begin F-bit. At one boundary a stalled cycle is inserted between the two, so the error has to be held as pending first. The bench judges the outcome from the transmitted check bits of each multiframe, comparing them bit by bit with independently computed remainders, inverted or not.

// File: rtl/esf_crc6_pkg.sv
package esf_crc6_pkg;
  localparam int               CRC_W       = 6;
  localparam logic [CRC_W-1:0] CRC_POLY    = 6'b000011;  // x^1 + x^0 terms
  localparam int               MF_FRAMES   = 24;
  localparam int               SLOT_STRIDE = 4;
  localparam int               SLOT_PHASE  = 1;
  localparam int               HALF_FRAME  = 12;
endpackage

// File: rtl/esf_frame_pos.sv
module esf_frame_pos #(
  parameter int FRAMES = 24,
  parameter int STRIDE = 4,
  parameter int PHASE  = 1,
  parameter int HALF   = 12,
  parameter int SLOTS  = 6,
  localparam int FW    = $clog2(FRAMES),
  localparam int IW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fbit,
  input  logic          mfb,
  input  logic          half_off,
  output logic          mf_start,
  output logic          slot_hit,
  output logic [IW-1:0] slot_bit,
  output logic          mark
);
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  logic [FW-1:0] frm_q;
  logic [FW-1:0] frm_n;
  logic [FW-1:0] frm_now;
  logic [FW-1:0] grp;
  logic          fpulse;

  // frame index of the F-bit being presented in this cycle
  always_comb begin
    fpulse = en & fbit;
    if (mfb || frm_q == LAST) begin
      frm_now = '0;
    end else begin
      frm_now = frm_q + FW'(1);
    end
    frm_n    = fpulse ? frm_now : frm_q;
    grp      = frm_now / FW'(STRIDE);
    mf_start = fpulse & mfb;
    slot_hit = fpulse & ((frm_now % FW'(STRIDE)) == FW'(PHASE)) & (grp < FW'(SLOTS));
    slot_bit = IW'(SLOTS - 1) - grp[IW-1:0];
    mark     = fpulse & (mfb | (~half_off & (frm_now == FW'(HALF))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= LAST;
    end else begin
      frm_q <= frm_n;
    end
  end
endmodule

// File: rtl/esf_crc_acc.sv
module esf_crc_acc #(
  parameter int            CW   = 6,
  parameter logic [CW-1:0] POLY = 6'b000011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fbit,
  input  logic          mf_start,
  input  logic          din,
  output logic [CW-1:0] crc_prev,
  output logic          prev_full
);
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_n;
  logic [CW-1:0] seed;
  logic [CW-1:0] prev_n;
  logic          d_eff;
  logic          fb;
  logic          seen_q;
  logic          seen_n;
  logic          full_n;

  always_comb begin
    d_eff  = fbit ? 1'b1 : din;           // framing positions count as ones
    seed   = mf_start ? '0 : run_q;
    fb     = d_eff ^ seed[CW-1];
    run_n  = en ? ({seed[CW-2:0], 1'b0} ^ ({CW{fb}} & POLY)) : run_q;
    prev_n = mf_start ? run_q : crc_prev;
    full_n = mf_start ? seen_q : prev_full;
    seen_n = seen_q | mf_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      crc_prev  <= '0;
      prev_full <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      run_q     <= run_n;
      crc_prev  <= prev_n;
      prev_full <= full_n;
      seen_q    <= seen_n;
    end
  end
endmodule

// File: rtl/esf_crc6_engine.sv
module esf_crc6_engine
  import esf_crc6_pkg::*;
#(
  parameter int            CW     = CRC_W,
  parameter logic [CW-1:0] POLY   = CRC_POLY,
  parameter int            FRAMES = MF_FRAMES,
  parameter int            STRIDE = SLOT_STRIDE,
  parameter int            PHASE  = SLOT_PHASE,
  parameter int            HALF   = HALF_FRAME
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic rx_bit,
  input  logic rx_fbit,
  input  logic rx_mfb,
  input  logic tx_en,
  input  logic tx_bit,
  input  logic tx_fbit,
  input  logic tx_mfb,
  input  logic inv_en,
  input  logic irq_mask,
  input  logic irq_clr,
  input  logic half_mark_off,
  output logic tx_out,
  output logic rx_mark,
  output logic tx_mark,
  output logic crc_err,
  output logic alarm_irq
);
  localparam int IW = $clog2(CW);

  // ---------------- receive direction ----------------
  logic          rx_mf;
  logic          rx_slot;
  logic [IW-1:0] rx_sbit;
  logic [CW-1:0] rx_ref;
  logic          rx_ref_ok;
  logic          mis_q;
  logic          mis_n;
  logic          err_now;
  logic          irq_n;

  esf_frame_pos #(
    .FRAMES(FRAMES), .STRIDE(STRIDE), .PHASE(PHASE), .HALF(HALF), .SLOTS(CW)
  ) u_rx_pos (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .fbit(rx_fbit), .mfb(rx_mfb),
    .half_off(half_mark_off), .mf_start(rx_mf), .slot_hit(rx_slot),
    .slot_bit(rx_sbit), .mark(rx_mark)
  );

  esf_crc_acc #(.CW(CW), .POLY(POLY)) u_rx_acc (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .fbit(rx_fbit), .mf_start(rx_mf),
    .din(rx_bit), .crc_prev(rx_ref), .prev_full(rx_ref_ok)
  );

  always_comb begin
    mis_n   = rx_mf ? 1'b0 : (mis_q | (rx_slot & (rx_bit != rx_ref[rx_sbit])));
    err_now = rx_mf & rx_ref_ok & mis_q;
    irq_n   = (alarm_irq & ~irq_clr) | (err_now & irq_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mis_q     <= 1'b0;
      crc_err   <= 1'b0;
      alarm_irq <= 1'b0;
    end else begin
      mis_q     <= mis_n;
      crc_err   <= err_now;
      alarm_irq <= irq_n;
    end
  end

  // ---------------- transmit direction ----------------
  logic          tx_mf;
  logic          tx_slot;
  logic [IW-1:0] tx_sbit;
  logic [CW-1:0] tx_ref;
  logic          tx_ref_ok;
  logic [CW-1:0] tx_word;
  logic          pend_q;
  logic          pend_n;
  logic          inv_q;
  logic          inv_n;

  esf_frame_pos #(
    .FRAMES(FRAMES), .STRIDE(STRIDE), .PHASE(PHASE), .HALF(HALF), .SLOTS(CW)
  ) u_tx_pos (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .fbit(tx_fbit), .mfb(tx_mfb),
    .half_off(half_mark_off), .mf_start(tx_mf), .slot_hit(tx_slot),
    .slot_bit(tx_sbit), .mark(tx_mark)
  );

  esf_crc_acc #(.CW(CW), .POLY(POLY)) u_tx_acc (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .fbit(tx_fbit), .mf_start(tx_mf),
    .din(tx_bit), .crc_prev(tx_ref), .prev_full(tx_ref_ok)
  );

  always_comb begin
    pend_n  = tx_mf ? 1'b0 : (pend_q | crc_err);
    inv_n   = tx_mf ? (inv_en & (pend_q | crc_err)) : inv_q;
    tx_word = tx_ref_ok ? tx_ref : '0;
    tx_out  = tx_slot ? (tx_word[tx_sbit] ^ inv_q) : tx_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      inv_q  <= inv_n;
    end
  end
endmodule

// File: rtl/esf_crc6_engine_chk.sv
module esf_crc6_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic rx_fbit,
  input logic rx_mfb,
  input logic tx_en,
  input logic tx_bit,
  input logic tx_fbit,
  input logic irq_mask,
  input logic irq_clr,
  input logic tx_out,
  input logic rx_mark,
  input logic tx_mark,
  input logic crc_err,
  input logic alarm_irq
);
  AST_ERR_AFTER_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> $past(rx_en && rx_fbit && rx_mfb)); // R5

  AST_IRQ_RISES_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> crc_err); // R7

  AST_IRQ_SET_BY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && $past(irq_mask)) |-> alarm_irq); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alarm_irq) && !$past(irq_clr)) |-> alarm_irq); // R7

  AST_TX_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && tx_fbit) |-> (tx_out == tx_bit)); // R4

  AST_RX_MARK_ON_FBIT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mark |-> (rx_en && rx_fbit)); // R9

  AST_TX_MARK_ON_FBIT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mark |-> (tx_en && tx_fbit)); // R9
endmodule

bind esf_crc6_engine esf_crc6_engine_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_fbit(rx_fbit), .rx_mfb(rx_mfb),
  .tx_en(tx_en), .tx_bit(tx_bit), .tx_fbit(tx_fbit), .irq_mask(irq_mask),
  .irq_clr(irq_clr), .tx_out(tx_out), .rx_mark(rx_mark), .tx_mark(tx_mark),
  .crc_err(crc_err), .alarm_irq(alarm_irq)
);

// File: tb/test_esf_crc6_engine.sv
module test_esf_crc6_engine;
  localparam int CLK_P = 10;
  localparam int FB    = 8;           // bits per frame used by the bench
  localparam int MFB   = 24 * FB;     // bits per multiframe
  localparam int NR    = 7;
  localparam int TOT   = NR * MFB;
  // row bits: [4] corrupt check bit, [3] inv_en, [2] irq_mask, [1] half_mark_off, [0] expect inverted tx
  localparam logic [4:0] ROWS [NR] = '{5'b01100, 5'b11100, 5'b01011, 5'b10100,
                                       5'b00110, 5'b11100, 5'b01101};

  logic clk, rst_n;
  logic rx_en, rx_bit, rx_fbit, rx_mfb;
  logic tx_en, tx_bit, tx_fbit, tx_mfb;
  logic inv_en, irq_mask, irq_clr, half_mark_off;
  logic tx_out, rx_mark, tx_mark, crc_err, alarm_irq;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;
  bit  irq_exp = 0;
  logic [5:0] crc_tab [NR];

  esf_crc6_engine i_esf_crc6_engine (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit), .rx_fbit(rx_fbit),
    .rx_mfb(rx_mfb), .tx_en(tx_en), .tx_bit(tx_bit), .tx_fbit(tx_fbit),
    .tx_mfb(tx_mfb), .inv_en(inv_en), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .half_mark_off(half_mark_off), .tx_out(tx_out), .rx_mark(rx_mark),
    .tx_mark(tx_mark), .crc_err(crc_err), .alarm_irq(alarm_irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic dat(input int m, input int w);
    return ((m * 29 + w * 7 + w / 8) % 5) < 2;
  endfunction

  // remainder of x^6 + x + 1 over one multiframe, F positions taken as ones
  function automatic logic [5:0] mf_crc(input int m);
    logic [5:0] c = '0;
    for (int w = 0; w < MFB; w++) begin
      logic d  = (w % FB == 0) ? 1'b1 : dat(m, w);
      logic fb = d ^ c[5];
      c = {c[4:0], 1'b0} ^ (fb ? 6'b000011 : 6'b000000);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    end
  endtask

  // one clock: receive stream position srx, transmit stream position stx (one bit behind)
  task automatic do_cycle(input int srx, input bit stall);
    int  stx = srx - 1;
    bit  arx = !stall && srx < TOT;
    bit  atx = !stall && stx >= 0 && stx < TOT;
    int  row = (srx < TOT) ? srx / MFB : NR - 1;
    int  mr  = srx / MFB,  wr = srx % MFB, fr = wr / FB;
    int  mt  = stx / MFB,  wt = (stx < 0) ? 1 : stx % MFB, ft = wt / FB;
    bit  e_rm, e_tm, e_err, e_tx;
    string req;
    @(negedge clk);
    inv_en        = ROWS[row][3];
    irq_mask      = ROWS[row][2];
    half_mark_off = ROWS[row][1];
    if (stall) begin
      {rx_en, rx_bit, rx_fbit, rx_mfb} = 4'b0111;
      {tx_en, tx_bit, tx_fbit, tx_mfb} = 4'b0111;
    end else begin
      rx_en = arx; tx_en = atx;
      rx_fbit = arx && (wr % FB == 0);
      rx_mfb  = rx_fbit && fr == 0;
      if (!arx) rx_bit = 1'b0;
      else if (!rx_fbit) rx_bit = dat(mr, wr);
      else if (fr % 4 == 1)
        rx_bit = ((mr == 0) ? 1'b0 : crc_tab[mr-1][5 - fr/4]) ^ (ROWS[mr][4] && fr == 9);
      else rx_bit = 1'b0;
      tx_fbit = atx && (wt % FB == 0);
      tx_mfb  = tx_fbit && ft == 0;
      tx_bit  = (atx && !tx_fbit) ? dat(mt, wt) : 1'b0;
    end
    #1;
    e_rm = arx && rx_fbit && (fr == 0 || (fr == 12 && !half_mark_off));
    e_tm = atx && tx_fbit && (ft == 0 || (ft == 12 && !half_mark_off));
    chk(rx_mark == e_rm, "R9 rx_mark", rx_mark, e_rm);
    chk(tx_mark == e_tm, "R9 tx_mark", tx_mark, e_tm);
    if (atx && tx_fbit && ft % 4 == 1) begin
      e_tx = ((mt == 0) ? 1'b0 : crc_tab[mt-1][5 - ft/4]) ^ ROWS[mt][0];
      req  = ROWS[mt][0] ? "R8 inverted check bit" : "R1/R2/R3/R6 check bit";
      chk(tx_out == e_tx, req, tx_out, e_tx);
    end else begin
      req = stall ? "R11 idle pass" : "R4 pass";
      chk(tx_out == tx_bit, req, tx_out, tx_bit);
    end
    @(posedge clk); #1;
    e_err = arx && rx_mfb && mr >= 2 && ROWS[mr-1][4];
    irq_exp = irq_exp | (e_err & irq_mask);
    req = stall ? "R11 crc_err" : "R5 crc_err";
    chk(crc_err == e_err, req, crc_err, e_err);
    chk(alarm_irq == irq_exp, "R7 alarm_irq", alarm_irq, irq_exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {rx_en, rx_bit, rx_fbit, rx_mfb, tx_en, tx_bit, tx_fbit, tx_mfb} = '0;
    {inv_en, irq_mask, irq_clr, half_mark_off} = '0;
    for (int m = 0; m < NR; m++) crc_tab[m] = mf_crc(m);
    repeat (3) @(posedge clk);
    #1;
    chk(crc_err == 1'b0, "R10 crc_err in reset", crc_err, 0);
    chk(alarm_irq == 1'b0, "R10 alarm_irq in reset", alarm_irq, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(crc_err == 1'b0, "R10 crc_err after reset", crc_err, 0);
    chk(alarm_irq == 1'b0, "R10 alarm_irq after reset", alarm_irq, 0);

    // table walk: stalls sprinkled in, one between an error pulse and the transmit begin
    for (int s = 0; s <= TOT; s++) begin
      if ((s % 50 == 7) || (s == 6 * MFB + 1)) do_cycle(s, 1'b1);
      do_cycle(s, 1'b0);
    end

    // directed: clear of the sticky flag
    chk(alarm_irq == 1'b1, "R7 flag held before clear", alarm_irq, 1);
    @(negedge clk);
    {rx_en, tx_en} = 2'b00;
    irq_clr = 1'b1;
    @(posedge clk); #1;
    chk(alarm_irq == 1'b0, "R7 flag cleared", alarm_irq, 0);
    @(negedge clk);
    irq_clr = 1'b0;
    @(posedge clk); #1;
    chk(alarm_irq == 1'b0, "R7 flag stays clear", alarm_irq, 0);
    chk(crc_err == 1'b0, "R5 no spurious pulse", crc_err, 0);

    summary();
    $finish;
  end
endmodule